// File: doc/BRIEF.md
# Control Register Mode Unit

This block holds the paging and mode control state of an x86-style core: the first and fourth control registers (CR0 and CR4) and the extended feature enable register (EFER). It accepts write requests to CR0 or CR4, applies the side effects each write implies, and keeps a small vector of derived mode flags that the rest of the pipeline reads without decoding the registers again. A CR0 write can move the core into or out of long mode. When leaving long mode the block asks for the upper half of the instruction pointer to be cleared. A write that changes paging-relevant bits raises a one-cycle TLB flush pulse.

The long-mode enable and no-execute enable bits come in as level inputs. A feature input tells the block whether SSE is present. A code-segment load strobe lets segment logic outside the block set the 64-bit code flag, but only while long mode is active. Every update is registered and appears in the cycle after the request.

Top module: `crx_mode_unit`

## Requirements
- R1: While `rstN` is low, `cr0Out`, `cr4Out`, `eferOut`, `hidFlags`, `tlbFlush` and `ipHiClear` are all zero. In the first cycle after reset is released, CR0 is written with 0x60000010 through the normal CR0 write path, and any external write strobe in that cycle is ignored.
- R2: A CR0 write sampled at a clock edge becomes visible after that edge. The stored value is the written data with bit 4 forced to 1.
- R3: On every accepted CR0 write, `hidFlags[0]` takes CR0 bit 0, `hidFlags[1]` takes the inverse of CR0 bit 0, and `hidFlags[4:2]` take CR0 bits 3:1.
- R4: An accepted CR0 write that changes bit 31, 16 or 0 raises `tlbFlush` for exactly the next cycle. With no accepted write, `tlbFlush` stays low.
- R5: A CR0 write that takes bit 31 from 0 to 1 while `lmeIn` is 1 and CR4 bit 5 is 1 sets `eferOut[10]` and `hidFlags[5]`.
- R6: A CR0 write that takes bit 31 from 0 to 1 while `lmeIn` is 1 and CR4 bit 5 is 0 is discarded: CR0 and the flags are unchanged and no flush pulse follows.
- R7: A CR0 write that takes bit 31 from 1 to 0 while long mode is active clears `eferOut[10]`, `hidFlags[5]` and `hidFlags[6]`, and pulses `ipHiClear` for one cycle. The same write outside long mode gives no pulse.
- R8: `wrSel` = 1 selects CR4, and the data is stored in the next cycle. A change of CR4 bit 7, 5 or 4 raises the one-cycle `tlbFlush` pulse.
- R9: When `sseAvail` is 0, bit 9 of a CR4 write is cleared before it is stored. `hidFlags[7]` follows the stored CR4 bit 9.
- R10: Every cycle, `eferOut[8]` and `eferOut[11]` register `lmeIn` and `nxeIn`. All other `eferOut` bits except bit 10 are zero.
- R11: A `csLoad` strobe sets `hidFlags[6]` to `csLong` only if long mode was active before that edge; otherwise it sets the flag to 0. A long-mode exit in the same cycle takes priority.
- R12: `wrSel` = 0 with `wrEn` = 1 selects CR0. A CR0 write never changes CR4, and a CR4 write never changes CR0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request strobe |
| wrSel | input | 1 | Target register: 0 CR0, 1 CR4 |
| wrData | input | 32 | Value to write |
| lmeIn | input | 1 | Long-mode enable bit of EFER |
| nxeIn | input | 1 | No-execute enable bit of EFER |
| sseAvail | input | 1 | SSE feature present |
| csLoad | input | 1 | Code segment load strobe |
| csLong | input | 1 | Loaded code segment is 64-bit |
| cr0Out | output | 32 | Current CR0 |
| cr4Out | output | 32 | Current CR4 |
| eferOut | output | 12 | EFER view: bit 8 LME, bit 10 LMA, bit 11 NXE |
| hidFlags | output | 8 | Flags: 0 PE, 1 ADDSEG, 2 MP, 3 EM, 4 TS, 5 LMA, 6 CS64, 7 OSFXSR |
| tlbFlush | output | 1 | One-cycle TLB flush pulse |
| ipHiClear | output | 1 | One-cycle request to zero the instruction pointer's upper half |

## Verification
A directed prologue drives the transitions that random data rarely reaches in order. It enters long mode with PAE set, loads a 64-bit code segment, leaves long mode, attempts an entry with PAE clear (which must be discarded), and turns paging off without long mode (which must not request the pointer clear). It also writes CR4 bit 9 with SSE both absent and present. Those last two cases separate the masking from the plain store. After that, several thousand random writes with biased paging and protection bits are compared every cycle against a reference model built from the requirements. Mixing CR0 and CR4 writes, toggling `lmeIn`, and issuing stray code-segment loads outside long mode shows whether the flush and mode decisions read the old register values or the new ones.

// File: rtl/crx_pkg.sv
package crx_pkg;
  localparam int Cr0Pe = 0;
  localparam int Cr0Mp = 1;
  localparam int Cr0Ts = 3;
  localparam int Cr0Et = 4;
  localparam int Cr0Wp = 16;
  localparam int Cr0Pg = 31;

  localparam int Cr4Pse    = 4;
  localparam int Cr4Pae    = 5;
  localparam int Cr4Pge    = 7;
  localparam int Cr4Osfxsr = 9;

  localparam int EferW   = 12;
  localparam int EferLme = 8;
  localparam int EferLma = 10;
  localparam int EferNxe = 11;

  localparam int FlagW      = 8;
  localparam int FlagPe     = 0;
  localparam int FlagAddSeg = 1;
  localparam int FlagMp     = 2;
  localparam int FlagTs     = 4;
  localparam int FlagLma    = 5;
  localparam int FlagCs64   = 6;
  localparam int FlagOsfxsr = 7;

  typedef struct packed {
    logic ld0;
    logic ld4;
    logic enterLong;
    logic exitLong;
    logic flush;
    logic ipClr;
    logic csLd;
  } crxStrobe_t;
endpackage

// File: rtl/crx_ctrl.sv
module crx_ctrl
  import crx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] INIT_CR0 = 32'h6000_0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lmeIn,
  input  logic              sseAvail,
  input  logic              csLoad,
  input  logic [DATA_W-1:0] cr0Q,
  input  logic [DATA_W-1:0] cr4Q,
  input  logic              lmaQ,
  output crxStrobe_t        stb,
  output logic [DATA_W-1:0] cr0Val,
  output logic [DATA_W-1:0] cr4Val
);
  localparam logic [DATA_W-1:0] Cr0FlushMask =
    (DATA_W'(1) << Cr0Pg) | (DATA_W'(1) << Cr0Wp) | (DATA_W'(1) << Cr0Pe);
  localparam logic [DATA_W-1:0] Cr4FlushMask =
    (DATA_W'(1) << Cr4Pge) | (DATA_W'(1) << Cr4Pae) | (DATA_W'(1) << Cr4Pse);

  logic initPending;
  logic cr0Req, cr4Req, pgRise, pgFall, blockEntry;
  logic flush0, flush4;

  always_ff @(posedge clk) begin
    if (!rstN) initPending <= 1'b1;
    else       initPending <= 1'b0;
  end

  always_comb begin
    cr0Req = initPending | (wrEn & ~wrSel);
    cr4Req = ~initPending & wrEn & wrSel;
    cr0Val = initPending ? INIT_CR0 : wrData;
    cr4Val = wrData;
    if (!sseAvail) cr4Val[Cr4Osfxsr] = 1'b0;

    pgRise     = ~cr0Q[Cr0Pg] & cr0Val[Cr0Pg];
    pgFall     = cr0Q[Cr0Pg] & ~cr0Val[Cr0Pg];
    blockEntry = pgRise & lmeIn & ~cr4Q[Cr4Pae];

    flush0 = |((cr0Val ^ cr0Q) & Cr0FlushMask);
    flush4 = |((cr4Val ^ cr4Q) & Cr4FlushMask);

    stb           = '0;
    stb.ld0       = cr0Req & ~blockEntry;
    stb.ld4       = cr4Req;
    stb.enterLong = stb.ld0 & pgRise & lmeIn;
    stb.exitLong  = stb.ld0 & pgFall & lmaQ;
    stb.ipClr     = stb.exitLong;
    stb.flush     = (stb.ld0 & flush0) | (stb.ld4 & flush4);
    stb.csLd      = csLoad;
  end

  // R1
  init_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initPending |=> !initPending);

  // R6
  blocked_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && !initPending && !cr4Q[Cr4Pae] && lmeIn && !cr0Q[Cr0Pg] && wrData[Cr0Pg])
      |-> !stb.ld0 && !stb.flush);
endmodule

// File: rtl/crx_datapath.sv
module crx_datapath
  import crx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  crxStrobe_t         stb,
  input  logic [DATA_W-1:0]  cr0Val,
  input  logic [DATA_W-1:0]  cr4Val,
  input  logic               lmeIn,
  input  logic               nxeIn,
  input  logic               csLong,
  output logic [DATA_W-1:0]  cr0Q,
  output logic [DATA_W-1:0]  cr4Q,
  output logic               lmaQ,
  output logic [EferW-1:0]   eferOut,
  output logic [FlagW-1:0]   hidFlags,
  output logic               tlbFlush,
  output logic               ipHiClear
);
  logic lmeQ, nxeQ;
  logic fPe, fAddSeg, fLma, fCs64, fOsfx;
  logic [2:0] fFpu;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cr0Q      <= '0;
      cr4Q      <= '0;
      lmaQ      <= 1'b0;
      lmeQ      <= 1'b0;
      nxeQ      <= 1'b0;
      fPe       <= 1'b0;
      fAddSeg   <= 1'b0;
      fFpu      <= '0;
      fLma      <= 1'b0;
      fCs64     <= 1'b0;
      fOsfx     <= 1'b0;
      tlbFlush  <= 1'b0;
      ipHiClear <= 1'b0;
    end else begin
      tlbFlush  <= stb.flush;
      ipHiClear <= stb.ipClr;
      lmeQ      <= lmeIn;
      nxeQ      <= nxeIn;
      if (stb.ld0) begin
        cr0Q    <= cr0Val | (DATA_W'(1) << Cr0Et);
        fPe     <= cr0Val[Cr0Pe];
        fAddSeg <= ~cr0Val[Cr0Pe];
        fFpu    <= cr0Val[Cr0Ts:Cr0Mp];
      end
      if (stb.enterLong) begin
        lmaQ <= 1'b1;
        fLma <= 1'b1;
      end else if (stb.exitLong) begin
        lmaQ <= 1'b0;
        fLma <= 1'b0;
      end
      if (stb.exitLong)  fCs64 <= 1'b0;
      else if (stb.csLd) fCs64 <= csLong & lmaQ;
      if (stb.ld4) begin
        cr4Q  <= cr4Val;
        fOsfx <= cr4Val[Cr4Osfxsr];
      end
    end
  end

  always_comb begin
    eferOut          = '0;
    eferOut[EferLme] = lmeQ;
    eferOut[EferLma] = lmaQ;
    eferOut[EferNxe] = nxeQ;
    hidFlags                   = '0;
    hidFlags[FlagPe]           = fPe;
    hidFlags[FlagAddSeg]       = fAddSeg;
    hidFlags[FlagTs:FlagMp]    = fFpu;
    hidFlags[FlagLma]          = fLma;
    hidFlags[FlagCs64]         = fCs64;
    hidFlags[FlagOsfxsr]       = fOsfx;
  end

  // R2
  et_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld0 |=> cr0Q[Cr0Et]);

  // R3
  pe_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld0 |=> (fPe == cr0Q[Cr0Pe]) && (fAddSeg != cr0Q[Cr0Pe]));

  // R4
  flush_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ld0 || stb.ld4) |=> !tlbFlush);

  // R5
  enter_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.enterLong |=> lmaQ && fLma && cr0Q[Cr0Pg]);

  // R7
  exit_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.exitLong |=> !lmaQ && !fLma && !fCs64 && ipHiClear);

  // R9
  osfx_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld4 |=> fOsfx == cr4Q[Cr4Osfxsr]);

  // R11
  cs64_in_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    fCs64 |-> lmaQ);
endmodule

// File: rtl/crx_mode_unit.sv
module crx_mode_unit
  import crx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] INIT_CR0 = 32'h6000_0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lmeIn,
  input  logic              nxeIn,
  input  logic              sseAvail,
  input  logic              csLoad,
  input  logic              csLong,
  output logic [DATA_W-1:0] cr0Out,
  output logic [DATA_W-1:0] cr4Out,
  output logic [EferW-1:0]  eferOut,
  output logic [FlagW-1:0]  hidFlags,
  output logic              tlbFlush,
  output logic              ipHiClear
);
  crxStrobe_t        stb;
  logic [DATA_W-1:0] cr0Val, cr4Val;
  logic              lmaQ;

  crx_ctrl #(.DATA_W(DATA_W), .INIT_CR0(INIT_CR0)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .lmeIn    (lmeIn),
    .sseAvail (sseAvail),
    .csLoad   (csLoad),
    .cr0Q     (cr0Out),
    .cr4Q     (cr4Out),
    .lmaQ     (lmaQ),
    .stb      (stb),
    .cr0Val   (cr0Val),
    .cr4Val   (cr4Val)
  );

  crx_datapath #(.DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cr0Val    (cr0Val),
    .cr4Val    (cr4Val),
    .lmeIn     (lmeIn),
    .nxeIn     (nxeIn),
    .csLong    (csLong),
    .cr0Q      (cr0Out),
    .cr4Q      (cr4Out),
    .lmaQ      (lmaQ),
    .eferOut   (eferOut),
    .hidFlags  (hidFlags),
    .tlbFlush  (tlbFlush),
    .ipHiClear (ipHiClear)
  );
endmodule

// File: tb/sim_crx_mode_unit.sv
`timescale 1ns/1ps
module sim_crx_mode_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        lmeIn = 1'b0, nxeIn = 1'b0, sseAvail = 1'b0;
  logic        csLoad = 1'b0, csLong = 1'b0;
  logic [31:0] cr0Out, cr4Out;
  logic [11:0] eferOut;
  logic [7:0]  hidFlags;
  logic        tlbFlush, ipHiClear;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mC0, mC4;
  logic [7:0]  mFl;
  logic        mLma, mLme, mNxe, mFlush, mIp, mInit;

  always #4 clk = ~clk;

  crx_mode_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .lmeIn(lmeIn), .nxeIn(nxeIn), .sseAvail(sseAvail), .csLoad(csLoad),
    .csLong(csLong), .cr0Out(cr0Out), .cr4Out(cr4Out), .eferOut(eferOut),
    .hidFlags(hidFlags), .tlbFlush(tlbFlush), .ipHiClear(ipHiClear)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] expEfer();
    logic [11:0] e = '0;
    e[8]  = mLme;
    e[10] = mLma;
    e[11] = mNxe;
    return e;
  endfunction

  task automatic compareAll();
    check("R2 R12 cr0", cr0Out, mC0);
    check("R8 R9 cr4", cr4Out, mC4);
    check("R10 efer", 32'(eferOut), 32'(expEfer()));
    check("R3 R5 R11 flags", 32'(hidFlags), 32'(mFl));
    check("R4 R6 tlbFlush", 32'(tlbFlush), 32'(mFlush));
    check("R7 ipHiClear", 32'(ipHiClear), 32'(mIp));
  endtask

  task automatic modelStep(bit we, bit sel, logic [31:0] d, bit lme, bit nxe,
                           bit sse, bit csl, bit csv);
    logic [31:0] v;
    bit isInit, exitNow, oldLma, pgUp;
    isInit = mInit; mInit = 1'b0;
    mFlush = 1'b0; mIp = 1'b0; exitNow = 1'b0; oldLma = mLma;
    if (isInit || (we && !sel)) begin
      v = isInit ? 32'h6000_0010 : d;
      pgUp = !mC0[31] && v[31];
      if (!(pgUp && lme && !mC4[5])) begin
        if (((v ^ mC0) & 32'h8001_0001) != 0) mFlush = 1'b1;
        if (pgUp && lme) mLma = 1'b1;
        else if (mC0[31] && !v[31] && mLma) begin
          mLma = 1'b0; exitNow = 1'b1; mIp = 1'b1;
        end
        mC0 = v | 32'h10;
        mFl[0] = v[0];
        mFl[1] = !v[0];
        mFl[4:2] = v[3:1];
      end
    end
    if (!isInit && we && sel) begin
      v = sse ? d : (d & ~32'h200);
      if (((v ^ mC4) & 32'hB0) != 0) mFlush = 1'b1;
      mC4 = v;
      mFl[7] = v[9];
    end
    if (exitNow) mFl[6] = 1'b0;
    else if (csl) mFl[6] = csv && oldLma;
    mFl[5] = mLma;
    mLme = lme;
    mNxe = nxe;
  endtask

  task automatic step(bit we, bit sel, logic [31:0] d, bit lme, bit nxe,
                      bit sse, bit csl, bit csv);
    wrEn = we; wrSel = sel; wrData = d; lmeIn = lme; nxeIn = nxe;
    sseAvail = sse; csLoad = csl; csLong = csv;
    modelStep(we, sel, d, lme, nxe, sse, csl, csv);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    void'($urandom(32'd2024));
    mC0 = '0; mC4 = '0; mFl = '0; mLma = 0; mLme = 0; mNxe = 0;
    mFlush = 0; mIp = 0; mInit = 0;
    lmeIn = 1'b1; nxeIn = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    compareAll();
    rstN = 1'b1;
    mInit = 1'b1;
    // R1: init write wins over an external CR0 write
    step(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    check("R1 init cr0", cr0Out, 32'h6000_0010);
    check("R1 init addseg", 32'(hidFlags), 32'h2);
    // R9: bit 9 dropped without SSE; R8 PAE change flushes
    step(1, 1, 32'h0000_0220, 0, 0, 0, 0, 0);
    check("R9 osfx masked", cr4Out, 32'h20);
    // R5: long mode entry
    step(1, 0, 32'h8000_0001, 1, 0, 0, 0, 0);
    check("R5 lma set", 32'(eferOut[10]), 32'd1);
    // R11: 64-bit code segment inside long mode
    step(0, 0, 32'h0, 1, 0, 0, 1, 1);
    check("R11 cs64 set", 32'(hidFlags[6]), 32'd1);
    // R7: exit long mode
    step(1, 0, 32'h0000_0011, 1, 0, 0, 0, 0);
    check("R7 ip clear", 32'(ipHiClear), 32'd1);
    // R11: no cs64 outside long mode
    step(0, 0, 32'h0, 1, 0, 0, 1, 1);
    check("R11 cs64 stays", 32'(hidFlags[6]), 32'd0);
    step(1, 1, 32'h0, 1, 0, 1, 0, 0);
    // R6: entry with PAE clear is discarded
    step(1, 0, 32'h8000_0001, 1, 0, 1, 0, 0);
    check("R6 cr0 kept", cr0Out, 32'h11);
    check("R6 no flush", 32'(tlbFlush), 32'd0);
    // R9: bit 9 kept with SSE
    step(1, 1, 32'h0000_0200, 0, 0, 1, 0, 0);
    check("R9 osfx flag", 32'(hidFlags[7]), 32'd1);
    // R7: paging off without long mode gives no pulse
    step(1, 0, 32'h8000_0001, 0, 0, 1, 0, 0);
    step(1, 0, 32'h0000_0001, 0, 0, 1, 0, 0);
    check("R7 no ip pulse", 32'(ipHiClear), 32'd0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d = $urandom;
      d[31] = ($urandom % 2) == 0;
      d[16] = ($urandom % 4) == 0;
      d[0]  = ($urandom % 2) == 0;
      d[5]  = ($urandom % 3) != 0;
      step(($urandom % 10) < 7, $urandom % 2, d, ($urandom % 4) != 0,
           $urandom % 2, $urandom % 2, ($urandom % 5) == 0, $urandom % 2);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule